// File: doc/BRIEF.md
# Deferred Snapshot Status Register Bank

This block sits beside a video front end and gives a host a consistent view of three status values: a 16-bit gain-control status word, a 16-bit noise measurement word, and the number of lines counted in the most recent complete frame. The line count comes from internal logic. A line counter advances on every line sync strobe. On every frame sync strobe it hands its count to a previous-frame register.

The host sees the values through a byte-wide register port. Each status value is split across two byte addresses. The host writes 1 to a capture request bit and then polls that bit. The block waits a set number of clock cycles. It then samples all three live values in one cycle into shadow registers and clears the request bit on the same edge. The shadow copies stay frozen until the next request, so the host can read the byte halves in any order without tearing.

Top module: `status_snap_top`

## Requirements
- R1: After reset, every readable address returns 00h, including the request register at 97h.
- R2: Writing a byte with bit 0 set to address 97h while no capture is pending starts a capture. Bit 0 of 97h then reads 1 for exactly CAPTURE_DELAY clock cycles after the write edge, and reads 0 afterwards.
- R3: The shadow registers load on the same edge that clears the request bit. The values they load are the live inputs present in the last cycle of the pending window.
- R4: While no new request is made, the shadow registers do not change, whatever happens on the live inputs and sync strobes.
- R5: Byte map: 3Ch holds gain bits 7:0 and 3Dh holds gain bits 15:8. 64h holds noise bits 7:0 and 65h holds noise bits 15:8. 9Ah holds line count bits 7:0. 9Bh holds line count bits 9:8 in its bits 1:0, with bits 7:2 reading 0. At 97h, bits 7:1 read 0.
- R6: The frame sync strobe counts as the first line of the new frame. A frame with k line strobe cycles between two frame strobes gives a count of k+1. When both strobes are high in the same cycle, the frame strobe takes precedence.
- R7: The line count saturates at 1023 and does not wrap.
- R8: While a capture is pending, a write of 0 or of 1 to bit 0 of 97h has no effect. The pending window is neither cut short nor restarted.
- R9: Writes to any address other than 97h are ignored. Reads of unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_sync_i | input | 1 | Line strobe, counts one line per high cycle |
| frame_sync_i | input | 1 | Frame strobe |
| gain_stat_i | input | 16 | Live gain-control status |
| noise_meas_i | input | 16 | Live noise measurement |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from reg_addr_i |

## Verification
The hardest case to reach from the ports is a second request, or a cancel, that arrives in the middle of a pending window. The bench writes to 97h at fixed cycle offsets inside the window it is polling. It then checks that the request bit still reads 1 for exactly CAPTURE_DELAY cycles in total.

Saturation needs more than a thousand line strobes between two frame strobes. The bench holds the line strobe high for long runs to get there. It sweeps the frame length across the byte boundary and beyond the limit.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int STAT_W = 16;
  localparam logic [7:0] ADDR_GAIN_LO  = 8'h3C;
  localparam logic [7:0] ADDR_GAIN_HI  = 8'h3D;
  localparam logic [7:0] ADDR_NOISE_LO = 8'h64;
  localparam logic [7:0] ADDR_NOISE_HI = 8'h65;
  localparam logic [7:0] ADDR_REQ      = 8'h97;
  localparam logic [7:0] ADDR_LINE_LO  = 8'h9A;
  localparam logic [7:0] ADDR_LINE_HI  = 8'h9B;
endpackage

// File: rtl/snap_line_counter.sv
module snap_line_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              frame_sync_i,
  output logic [LINE_W-1:0] prev_lines_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      prev_lines_o <= '0;
    end else if (frame_sync_i) begin
      prev_lines_o <= cnt_q;
      cnt_q        <= LINE_W'(1);
    end else if (line_sync_i && cnt_q != LINE_MAX) begin
      cnt_q <= cnt_q + LINE_W'(1);
    end
  end

  p_saturate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LINE_MAX && line_sync_i && !frame_sync_i) |=> cnt_q == LINE_MAX);
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> cnt_q == LINE_W'(1));
endmodule

// File: rtl/snap_capture_ctrl.sv
module snap_capture_ctrl #(
  parameter int CAPTURE_DELAY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pending_o,
  output logic snap_o
);
  localparam int TW = $clog2(CAPTURE_DELAY + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(CAPTURE_DELAY - 1);

  logic [TW-1:0] timer_q;

  assign snap_o = pending_o && timer_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      timer_q   <= '0;
    end else if (!pending_o) begin
      if (start_i) begin
        pending_o <= 1'b1;
        timer_q   <= T_LOAD;
      end
    end else if (snap_o) begin
      pending_o <= 1'b0;
    end else begin
      timer_q <= timer_q - TW'(1);
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && timer_q != '0) |=> pending_o);
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_o) |-> $past(snap_o));
  p_timer_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> timer_q <= T_LOAD);
endmodule

// File: rtl/status_snap_top.sv
module status_snap_top
  import snap_pkg::*;
#(
  parameter int CAPTURE_DELAY = 16,
  parameter int LINE_W        = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_sync_i,
  input  logic              frame_sync_i,
  input  logic [STAT_W-1:0] gain_stat_i,
  input  logic [STAT_W-1:0] noise_meas_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o
);
  logic [LINE_W-1:0] live_lines;
  logic [LINE_W-1:0] shd_lines_q;
  logic [STAT_W-1:0] shd_gain_q;
  logic [STAT_W-1:0] shd_noise_q;
  logic              pending;
  logic              snap;
  logic              start;
  logic [15:0]       line_ext;

  assign start = reg_wr_i && reg_addr_i == ADDR_REQ && reg_wdata_i[0];

  snap_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_sync_i  (line_sync_i),
    .frame_sync_i (frame_sync_i),
    .prev_lines_o (live_lines)
  );

  snap_capture_ctrl #(.CAPTURE_DELAY(CAPTURE_DELAY)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .pending_o (pending),
    .snap_o    (snap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_lines_q <= '0;
      shd_gain_q  <= '0;
      shd_noise_q <= '0;
    end else if (snap) begin
      shd_lines_q <= live_lines;
      shd_gain_q  <= gain_stat_i;
      shd_noise_q <= noise_meas_i;
    end
  end

  assign line_ext = 16'(shd_lines_q);

  always_comb begin
    unique case (reg_addr_i)
      ADDR_GAIN_LO:  reg_rdata_o = shd_gain_q[7:0];
      ADDR_GAIN_HI:  reg_rdata_o = shd_gain_q[15:8];
      ADDR_NOISE_LO: reg_rdata_o = shd_noise_q[7:0];
      ADDR_NOISE_HI: reg_rdata_o = shd_noise_q[15:8];
      ADDR_REQ:      reg_rdata_o = {7'b0, pending};
      ADDR_LINE_LO:  reg_rdata_o = line_ext[7:0];
      ADDR_LINE_HI:  reg_rdata_o = line_ext[15:8];
      default:       reg_rdata_o = 8'h00;
    endcase
  end

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap |=> $stable(shd_gain_q) && $stable(shd_noise_q) && $stable(shd_lines_q));
  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap |=> shd_gain_q == $past(gain_stat_i) && !pending);
endmodule

// File: tb/status_snap_top_test.sv
`timescale 1ns/1ps
module status_snap_top_test;
  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_s = 1'b0, frame_s = 1'b0;
  logic [15:0] gain = '0, noise = '0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  status_snap_top #(.CAPTURE_DELAY(D), .LINE_W(10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_sync_i(line_s), .frame_sync_i(frame_s),
    .gain_stat_i(gain), .noise_meas_i(noise), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic frame(input int k);
    @(negedge clk); frame_s = 1'b1;
    @(negedge clk); frame_s = 1'b0;
    if (k > 0) begin
      line_s = 1'b1;
      repeat (k) @(negedge clk);
      line_s = 1'b0;
    end
    frame_s = 1'b1;
    @(negedge clk); frame_s = 1'b0;
  endtask

  // start capture, poll request bit; returns number of cycles it read 1
  task automatic capture(output int cnt);
    logic [7:0] d;
    cnt = 0;
    wr_byte(8'h97, 8'h01);
    addr = 8'h97; #1;
    while (rdata[0] && cnt < 4 * D) begin
      cnt++;
      @(negedge clk); #1;
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [7:0] a, logic [15:0] g,
                                        logic [15:0] n, logic [9:0] l);
    case (a)
      8'h3C: return g[7:0];
      8'h3D: return g[15:8];
      8'h64: return n[7:0];
      8'h65: return n[15:8];
      8'h9A: return l[7:0];
      8'h9B: return {6'b0, l[9:8]};
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int c;
    int ks[10] = '{0, 1, 2, 254, 255, 510, 1021, 1022, 1023, 1500};
    logic [15:0] g_e, n_e;
    logic [9:0]  l_e;
    #12 rst_n = 1'b1;

    // R1: all addresses zero after reset
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d); check("R1", d, 8'h00);
    end

    // R2 R3 R5 R6 R7: sweep frame lengths
    for (int i = 0; i < 10; i++) begin
      gain  = 16'(16'h1357 * (i + 3));
      noise = 16'(16'hA5C3 ^ (i * 16'h0F11));
      frame(ks[i]);
      capture(c);
      check("R2 pending cycles", c, D);
      l_e = (ks[i] + 1 > 1023) ? 10'd1023 : 10'(ks[i] + 1);
      rd(8'h9A, d); check(ks[i] >= 1022 ? "R7 line lo" : "R6 line lo", d, {24'b0, l_e[7:0]});
      rd(8'h9B, d); check(ks[i] >= 1022 ? "R7 line hi" : "R6 line hi", d, {30'b0, l_e[9:8]});
      rd(8'h3D, d); check("R5 gain hi", d, gain[15:8]);
      rd(8'h3C, d); check("R5 gain lo", d, gain[7:0]);
      rd(8'h65, d); check("R5 noise hi", d, noise[15:8]);
      rd(8'h64, d); check("R5 noise lo", d, noise[7:0]);
    end
    g_e = gain; n_e = noise; l_e = 10'd1023;

    // R4: live changes without request leave shadows frozen
    gain = 16'hDEAD; noise = 16'hBEEF;
    frame(40);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d); check("R4 R5 frozen map", d, exp_rd(8'(a), g_e, n_e, l_e));
    end

    // R9: writes elsewhere ignored
    for (int a = 0; a < 256; a++)
      if (a != 8'h97) wr_byte(8'(a), 8'hFF);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d); check("R9 ignored write", d, exp_rd(8'(a), g_e, n_e, l_e));
    end

    // R8: write 0 while idle has no effect
    wr_byte(8'h97, 8'hFE);
    rd(8'h97, d); check("R8 write zero idle", d, 8'h00);

    // R3 sampling point + R8 mid-window writes
    gain = 16'h0001; noise = 16'h0002;
    wr_byte(8'h97, 8'h01);
    c = 0; addr = 8'h97; #1;
    while (rdata[0] && c < 4 * D) begin
      c++;
      if (c == 4) begin wdata = 8'h00; wr = 1'b1; end
      else if (c == 7) begin wdata = 8'h01; wr = 1'b1; end
      else wr = 1'b0;
      if (c == D) begin gain = 16'h4321; noise = 16'h8765; end
      @(negedge clk); wr = 1'b0; addr = 8'h97; #1;
    end
    check("R8 window unchanged", c, D);
    gain = 16'h1111; noise = 16'h2222;
    rd(8'h3C, d); check("R3 gain lo last cycle", d, 8'h21);
    rd(8'h3D, d); check("R3 gain hi last cycle", d, 8'h43);
    rd(8'h65, d); check("R3 noise hi last cycle", d, 8'h87);
    rd(8'h9A, d); check("R6 line after 40", d, 8'd41);

    // R6: frame and line together -> frame wins (restart at 1)
    @(negedge clk); frame_s = 1'b1; line_s = 1'b1;
    @(negedge clk); frame_s = 1'b0; line_s = 1'b1;
    repeat (4) @(negedge clk);
    line_s = 1'b0; frame_s = 1'b1;
    @(negedge clk); frame_s = 1'b0;
    capture(c);
    rd(8'h9A, d); check("R6 simultaneous strobes", d, 8'd5);
    rd(8'h97, d); check("R2 cleared", d, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule